// File: doc/BRIEF.md
# Word-Oriented Keystream Generator with Power-Map Filter

This block produces keystream for a stream cipher. Its state is a shift register of `N` words, each word one element of GF(2^M) written in a polynomial basis. Each step shifts the register by one word and inserts a new word at the tail. In running mode that new word is a linear combination of register words, built from multiplications by small powers of the field generator. A nonlinear permutation of the field reads the head word. The permutation is an exponentiation (x ⊕ 1)^E ⊕ 1, held in a lookup table that is computed at elaboration. The low `D` bits of the permuted word form one keystream word per clock. A plaintext input is XORed with that word to give ciphertext.

The state is filled by shifting words in through `iv_i` while `load_i` is high. A one-cycle `start_i` then starts a warm-up of `2·N` steps. During warm-up the tail word also mixes in the permutation of the head word and the word currently on `iv_i`. After warm-up the generator runs with the linear recurrence alone. The permutation output then passes through `P` register stages, so the design can be pipelined without touching any loop. `ks_valid_o` marks the words that come out of running mode.

Top module: `wgk_keygen`

## Requirements
- R1: After reset the register words are zero, the block is idle and `ks_valid_o` is 0.
- R2: While `load_i` is 1, each clock shifts the register towards the head and writes `iv_i` into the tail word. After `N` such clocks the first word loaded is the head. A load has priority over every other input and returns the block to idle.
- R3: A `start_i` pulse in idle begins warm-up. Warm-up lasts exactly `2·N` clocks, and `ks_valid_o` stays 0 throughout. A `start_i` seen outside idle has no effect.
- R4: In each warm-up step the new tail word is the linear feedback word XOR the permuted head word XOR `iv_i`.
- R5: In running mode the new tail word is `s0 ⊕ α^KA·s[TA] ⊕ α^KB·s[TB]`, with s0 the head word. The defaults are TA=1, KA=1, TB=3 and KB=2. `iv_i` has no effect in running mode.
- R6: Field elements use bit i as the coefficient of α^i, with α a root of x^7+x+1. The permutation is f(x) = (x ⊕ 1)^13 ⊕ 1. The keystream word is bits [D-1:0] of f applied to the head word.
- R7: `ks_valid_o` rises `P` clocks after running mode begins (default P=1). Word k after that point is derived from the head word of the k-th running-mode state, in order.
- R8: `ct_o` equals `pt_i` XOR `ks_o` at all times.
- R9: In running mode a nonzero register state never becomes the all-zero state.
- R10: A `load_i` during warm-up or running mode drops `ks_valid_o` to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Shift `iv_i` into the register tail |
| iv_i | input | M | Load word, and warm-up mixing word |
| start_i | input | 1 | Begin warm-up when idle |
| pt_i | input | D | Plaintext word |
| ks_valid_o | output | 1 | Keystream word valid |
| ks_o | output | D | Keystream word |
| ct_o | output | D | Ciphertext word |

## Verification
The hardest condition to reach from the ports is the claim that the register never reaches all zeros. The state cannot be seen directly, and only four bits of each permuted head word come out. The bench runs more than a thousand running-mode words from a nonzero load against an independent model of the field arithmetic. It also checks that no `2·N` consecutive keystream words are all zero, which is what an all-zero register would produce, since f(0)=0. The bench drives a changing `iv_i` during running mode and start pulses outside idle, and it aborts a run with a load. This shows those inputs reach the state only where the requirements allow.

// File: rtl/wgk_pkg.sv
package wgk_pkg;

  typedef enum logic [1:0] {
    WGK_IDLE = 2'd0,
    WGK_WARM = 2'd1,
    WGK_RUN  = 2'd2
  } wgk_mode_e;

  // multiply by alpha once: shift left, fold the overflow bit back via the low poly terms
  function automatic logic [15:0] gf_xtime(input logic [15:0] a, input int m,
                                           input logic [15:0] poly_low);
    logic [15:0] r;
    logic        top;
    top = a[m-1];
    r   = (a << 1) & ((16'd1 << m) - 16'd1);
    if (top) r = r ^ poly_low;
    return r;
  endfunction

  // multiply by alpha^k: k wired shifts with a few XORs each
  function automatic logic [15:0] gf_mul_alpha_k(input logic [15:0] a, input int k,
                                                 input int m, input logic [15:0] poly_low);
    logic [15:0] r;
    r = a;
    for (int i = 0; i < k; i++) r = gf_xtime(r, m, poly_low);
    return r;
  endfunction

  // shift-and-add field multiply
  function automatic logic [15:0] gf_mul(input logic [15:0] a, input logic [15:0] b,
                                         input int m, input logic [15:0] poly_low);
    logic [15:0] acc;
    logic [15:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 16; i++) begin
      if (i < m) begin
        if (b[i]) acc = acc ^ sh;
        sh = gf_xtime(sh, m, poly_low);
      end
    end
    return acc;
  endfunction

  // f(x) = (x + 1)^e + 1, computed by repeated multiplication
  function automatic logic [15:0] perm_value(input logic [15:0] x, input int e,
                                             input int m, input logic [15:0] poly_low);
    logic [15:0] y;
    logic [15:0] r;
    y = x ^ 16'd1;
    r = 16'd1;
    for (int i = 0; i < e; i++) r = gf_mul(r, y, m, poly_low);
    return r ^ 16'd1;
  endfunction

endpackage

// File: rtl/wgk_ctrl.sv
module wgk_ctrl #(
  parameter int N = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               start_i,
  output wgk_pkg::wgk_mode_e mode_o,
  output logic               warm_last_o
);
  import wgk_pkg::*;

  localparam int WARM_STEPS = 2 * N;
  localparam int CW         = $clog2(WARM_STEPS + 1);

  wgk_mode_e      mode_q;
  logic [CW-1:0]  cnt_q;

  assign warm_last_o = (mode_q == WGK_WARM) && (cnt_q == CW'(WARM_STEPS - 1));
  assign mode_o      = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= WGK_IDLE;
      cnt_q  <= '0;
    end else if (load_i) begin
      mode_q <= WGK_IDLE;
      cnt_q  <= '0;
    end else begin
      unique case (mode_q)
        WGK_IDLE: if (start_i) begin
          mode_q <= WGK_WARM;
          cnt_q  <= '0;
        end
        WGK_WARM: if (warm_last_o) mode_q <= WGK_RUN;
                  else             cnt_q  <= cnt_q + 1'b1;
        default: mode_q <= WGK_RUN;
      endcase
    end
  end

  assert_warm_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == WGK_WARM) |-> (cnt_q <= CW'(WARM_STEPS - 1)));

  assert_warm_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_last_o && !load_i) |=> (mode_q == WGK_RUN));

  assert_start_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == WGK_RUN) && !load_i) |=> (mode_q == WGK_RUN));

endmodule

// File: rtl/wgk_lfsr.sv
module wgk_lfsr #(
  parameter int          M     = 7,
  parameter int          N     = 5,
  parameter logic [15:0] POLY  = 16'h0003,
  parameter int          TAP_A = 1,
  parameter int          K_A   = 1,
  parameter int          TAP_B = 3,
  parameter int          K_B   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [M-1:0] iv_i,
  input  logic         warm_step_i,
  input  logic         run_step_i,
  input  logic [M-1:0] nl_i,
  output logic [M-1:0] head_o,
  output logic         nonzero_o
);
  import wgk_pkg::*;

  logic [M-1:0] s_q [N];
  logic [M-1:0] lin_fb;
  logic [M-1:0] tail_d;
  logic         shift_en;

  assign lin_fb = s_q[0]
                ^ M'(gf_mul_alpha_k(16'(s_q[TAP_A]), K_A, M, POLY))
                ^ M'(gf_mul_alpha_k(16'(s_q[TAP_B]), K_B, M, POLY));

  always_comb begin
    if (load_i)           tail_d = iv_i;
    else if (warm_step_i) tail_d = lin_fb ^ nl_i ^ iv_i;
    else                  tail_d = lin_fb;
  end

  assign shift_en = load_i || warm_step_i || run_step_i;

  for (genvar i = 0; i < N - 1; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)        s_q[i] <= '0;
      else if (shift_en) s_q[i] <= s_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        s_q[N-1] <= '0;
    else if (shift_en) s_q[N-1] <= tail_d;
  end

  always_comb begin
    nonzero_o = 1'b0;
    for (int i = 0; i < N; i++) nonzero_o = nonzero_o | (|s_q[i]);
  end

  assign head_o = s_q[0];

  assert_state_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_step_i && !load_i && nonzero_o) |=> nonzero_o);

  assert_run_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_step_i && !load_i) |=> (s_q[0] == $past(s_q[1])));

  assert_load_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (s_q[N-1] == $past(iv_i)));

endmodule

// File: rtl/wgk_perm.sv
module wgk_perm #(
  parameter int          M    = 7,
  parameter int          D    = 4,
  parameter int          P    = 1,
  parameter int          EXP  = 13,
  parameter logic [15:0] POLY = 16'h0003
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         run_i,
  input  logic [M-1:0] x_i,
  output logic [M-1:0] nl_o,
  output logic [D-1:0] ks_o,
  output logic         valid_o
);
  import wgk_pkg::*;

  localparam int ENTRIES = 2 ** M;

  logic [M-1:0] perm_tbl [ENTRIES];
  logic [D-1:0] dat_q    [P];
  logic [P-1:0] vld_q;

  for (genvar v = 0; v < ENTRIES; v++) begin : g_tbl
    localparam logic [15:0] PV = perm_value(16'(v), EXP, M, POLY);
    assign perm_tbl[v] = PV[M-1:0];
  end

  assign nl_o = perm_tbl[x_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q[0] <= '0;
      vld_q[0] <= 1'b0;
    end else begin
      dat_q[0] <= nl_o[D-1:0];
      vld_q[0] <= run_i && !flush_i;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_pipe
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dat_q[k] <= '0;
        vld_q[k] <= 1'b0;
      end else begin
        dat_q[k] <= dat_q[k-1];
        vld_q[k] <= vld_q[k-1] && !flush_i;
      end
    end
  end

  assign ks_o    = dat_q[P-1];
  assign valid_o = vld_q[P-1];

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0));

endmodule

// File: rtl/wgk_keygen.sv
module wgk_keygen #(
  parameter int          M     = 7,
  parameter int          N     = 5,
  parameter int          D     = 4,
  parameter int          P     = 1,
  parameter int          EXP   = 13,
  parameter logic [15:0] POLY  = 16'h0003,
  parameter int          TAP_A = 1,
  parameter int          K_A   = 1,
  parameter int          TAP_B = 3,
  parameter int          K_B   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [M-1:0] iv_i,
  input  logic         start_i,
  input  logic [D-1:0] pt_i,
  output logic         ks_valid_o,
  output logic [D-1:0] ks_o,
  output logic [D-1:0] ct_o
);
  import wgk_pkg::*;

  wgk_mode_e    mode;
  logic         warm_last;
  logic         warm_step;
  logic         run_step;
  logic [M-1:0] head;
  logic [M-1:0] nl;
  logic         state_nonzero;

  assign warm_step = (mode == WGK_WARM) && !load_i;
  assign run_step  = (mode == WGK_RUN)  && !load_i;

  wgk_ctrl #(.N(N)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .start_i     (start_i),
    .mode_o      (mode),
    .warm_last_o (warm_last)
  );

  wgk_lfsr #(.M(M), .N(N), .POLY(POLY), .TAP_A(TAP_A), .K_A(K_A),
             .TAP_B(TAP_B), .K_B(K_B)) u_lfsr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .iv_i        (iv_i),
    .warm_step_i (warm_step),
    .run_step_i  (run_step),
    .nl_i        (nl),
    .head_o      (head),
    .nonzero_o   (state_nonzero)
  );

  wgk_perm #(.M(M), .D(D), .P(P), .EXP(EXP), .POLY(POLY)) u_perm (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (load_i),
    .run_i   (run_step),
    .x_i     (head),
    .nl_o    (nl),
    .ks_o    (ks_o),
    .valid_o (ks_valid_o)
  );

  assign ct_o = pt_i ^ ks_o;

  assert_valid_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid_o |-> (mode == WGK_RUN));

  assert_load_drops_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !ks_valid_o);

  assert_warm_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WGK_WARM) |-> !ks_valid_o);

  assert_idle_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (mode == WGK_IDLE));

  assert_last_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_last && !load_i) |=> !warm_last);

endmodule

// File: tb/wgk_keygen_tb.sv
`timescale 1ns/1ps
module wgk_keygen_tb;
  localparam int M = 7, N = 5, D = 4, P = 1, EXP = 13;
  localparam logic [13:0] FULL_POLY = 14'h0083;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic         start = 1'b0;
  logic [M-1:0] iv = '0;
  logic [D-1:0] pt = '0;
  logic         ks_valid;
  logic [D-1:0] ks;
  logic [D-1:0] ct;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wgk_keygen u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .iv_i(iv), .start_i(start),
    .pt_i(pt), .ks_valid_o(ks_valid), .ks_o(ks), .ct_o(ct)
  );

  // reference model
  logic [M-1:0] ms [N];
  int           mmode;   // 0 idle, 1 warm-up, 2 run
  int           mcnt;
  logic [D-1:0] md [P];
  logic         mv [P];

  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [13:0] pr;
    pr = '0;
    for (int i = 0; i < M; i++) if (b[i]) pr = pr ^ (14'(a) << i);
    for (int bb = 12; bb >= M; bb--) if (pr[bb]) pr = pr ^ (FULL_POLY << (bb - M));
    return pr[M-1:0];
  endfunction

  function automatic logic [M-1:0] fperm(input logic [M-1:0] x);
    logic [M-1:0] r;
    logic [M-1:0] base;
    int e;
    r = 7'd1; base = x ^ 7'd1; e = EXP;
    while (e > 0) begin
      if (e % 2 == 1) r = fmul(r, base);
      base = fmul(base, base);
      e = e / 2;
    end
    return r ^ 7'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) ms[i] = '0;
    mmode = 0; mcnt = 0;
    for (int i = 0; i < P; i++) begin md[i] = '0; mv[i] = 1'b0; end
  endtask

  task automatic model_edge(input logic l, input logic s, input logic [M-1:0] v);
    logic [M-1:0] ph, lin, nw;
    ph  = fperm(ms[0]);
    lin = ms[0] ^ fmul(ms[1], 7'd2) ^ fmul(ms[3], 7'd4);
    for (int i = P - 1; i > 0; i--) begin md[i] = md[i-1]; mv[i] = mv[i-1] && !l; end
    md[0] = ph[D-1:0];
    mv[0] = (mmode == 2) && !l;
    if (l || mmode != 0) begin
      nw = l ? v : (mmode == 1) ? (lin ^ ph ^ v) : lin;
      for (int i = 0; i < N - 1; i++) ms[i] = ms[i+1];
      ms[N-1] = nw;
    end
    if (l) begin mmode = 0; mcnt = 0; end
    else if (mmode == 0 && s) begin mmode = 1; mcnt = 0; end
    else if (mmode == 1) begin
      if (mcnt == 2 * N - 1) mmode = 2; else mcnt = mcnt + 1;
    end
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int zero_run = 0;
  int max_zero_run = 0;

  task automatic cycle(input logic l, input logic s, input logic [M-1:0] v,
                       input logic [D-1:0] p, input string req);
    load = l; start = s; iv = v; pt = p;
    @(posedge clk);
    model_edge(l, s, v);
    @(negedge clk);
    check_eq(req, "valid", int'(ks_valid), int'(mv[P-1]));
    check_eq({req, " R6"}, "keystream", int'(ks), int'(md[P-1]));
    check_eq("R8", "ciphertext", int'(ct), int'(p ^ md[P-1]));
    if (ks_valid) begin
      if (ks == '0) zero_run++; else zero_run = 0;
      if (zero_run > max_zero_run) max_zero_run = zero_run;
    end
  endtask

  task automatic load_words(input logic [M-1:0] seed);
    for (int k = 0; k < N; k++) cycle(1'b1, 1'b0, M'(seed + 7'(k * 37)), '0, "R2");
  endtask

  task automatic t_reset();
    check_eq("R1", "valid after reset", int'(ks_valid), 0);
    check_eq("R1", "ks after reset", int'(ks), 0);
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 7'h55, 4'h3, "R1");
  endtask

  task automatic t_long_run();
    int to_valid;
    load_words(7'h13);
    cycle(1'b0, 1'b1, 7'h00, 4'h0, "R3");
    to_valid = 1;
    for (int k = 0; k < 2 * N; k++) begin
      cycle(1'b0, 1'b0, M'(7'h21 + 7'(k * 5)), 4'h0, "R3 R4");
      to_valid++;
      check_eq("R3", "valid low in warm-up", int'(ks_valid), 0);
    end
    while (!ks_valid && to_valid < 40) begin
      cycle(1'b0, 1'b0, 7'h7f, 4'h9, "R7");
      to_valid++;
    end
    check_eq("R7", "clocks from start to first valid", to_valid, 2 * N + P + 1);
    zero_run = 0; max_zero_run = 0;
    for (int k = 0; k < 1100; k++)
      cycle(1'b0, 1'b0, M'(k * 13), D'(k * 3), "R5 R7");
    check_eq("R9", "longest zero-word run below 2N", int'(max_zero_run < 2 * N), 1);
  endtask

  task automatic t_start_ignored();
    for (int k = 0; k < 6; k++) cycle(1'b0, 1'b1, 7'h2a, 4'h5, "R3 start ignored");
    check_eq("R3", "valid kept after start in run", int'(ks_valid), 1);
  endtask

  task automatic t_load_abort();
    cycle(1'b1, 1'b0, 7'h44, 4'h0, "R10");
    check_eq("R10", "valid after load in run", int'(ks_valid), 0);
    for (int k = 1; k < N; k++) cycle(1'b1, 1'b0, M'(7'h44 + 7'(k)), 4'h0, "R2");
    cycle(1'b0, 1'b1, 7'h01, 4'h0, "R3");
    for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0, 7'h0f, 4'h0, "R4");
    cycle(1'b1, 1'b0, 7'h09, 4'h0, "R10 warm abort");
    check_eq("R10", "valid after load in warm-up", int'(ks_valid), 0);
    for (int k = 1; k < N; k++) cycle(1'b1, 1'b0, M'(7'h30 + 7'(k * 3)), 4'h0, "R2");
    cycle(1'b0, 1'b1, 7'h00, 4'h0, "R3");
    for (int k = 0; k < 2 * N + 60; k++) cycle(1'b0, 1'b0, M'(k), 4'ha, "R4 R5");
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_long_run();
    t_start_ignored();
    t_load_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule